// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block stretches each external bus cycle by a number of wait states. Three configuration codes are captured once, on the first clock after reset is released. A 3-bit ready-limit code caps how many wait states an external device may request. A 2-bit timing-mode code can add one mandatory wait state. A 2-bit width code selects the data width of the bus.

A bus cycle starts when `cycReq` is seen while the controller is idle. Once started, the controller samples the active-high `readyIn` at each decision edge. It keeps `stall` high until `readyIn` is seen high or the limit count is reached, whichever comes first. `cycDone` then pulses for one clock.

The resolved bus width is presented on `busIs16`. An illegal limit code or an illegal width code raises `cfgErr`. With either code illegal, the controller behaves as if the limit were zero.

Top module: `bus_wait_ctrl`

## Requirements
- R1: While `rstN` is low, `stall` and `cycDone` are 0. The configuration inputs are captured on the first clock after `rstN` goes high. Later changes on those inputs have no effect until the next reset.
- R2: With `readyIn` held low, the limit code sets the wait-state count: 3'b000 gives 0, 3'b100 gives 1, 3'b101 gives 2 and 3'b110 gives 3. Here the wait-state count is the number of clocks with `stall` high.
- R3: If `readyIn` is seen high after d wait states of the ready phase, the cycle ends with min(d, limit) ready-phase wait states. `readyIn` is also sampled at the request edge, so d = 0 gives none.
- R4: Limit code 3'b111 has no limit, and the ready phase lasts exactly until `readyIn` is seen high. For example, d = 20 gives 20 wait states.
- R5: With limit code 3'b000, `readyIn` is ignored and the cycle never stalls for it.
- R6: Limit codes 3'b001, 3'b010 and 3'b011 are illegal. They set `cfgErr` to 1, and every cycle then behaves as with limit 0.
- R7: Timing mode 2'b00 adds one mandatory wait state before ready sampling begins, and this wait state does not count toward the limit. Modes 2'b01, 2'b10 and 2'b11 add none.
- R8: The width code drives `busIs16` as follows: 2'b01 gives 1 and 2'b10 gives 0. 2'b11 passes `widthPin` straight through. 2'b00 is illegal, giving `busIs16` = 0 and `cfgErr` = 1.
- R9: `cycDone` is a one-clock pulse in the clock after the last wait state. `stall` is low while it is high, and the controller is idle on the next clock.
- R10: A request is accepted only while the controller is idle. Holding `cycReq` high through a cycle's wait states starts no second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLimit | input | 3 | Ready-limit code, captured after reset |
| cfgMode | input | 2 | Timing-mode code, captured after reset |
| cfgWidth | input | 2 | Bus-width code, captured after reset |
| widthPin | input | 1 | External width select used with width code 2'b11 (1 = 16-bit) |
| cycReq | input | 1 | Bus cycle request |
| readyIn | input | 1 | Active-high ready from the external device |
| stall | output | 1 | High during each wait state |
| cycDone | output | 1 | One-clock pulse ending a bus cycle |
| busIs16 | output | 1 | Resolved bus width (1 = 16-bit, 0 = 8-bit) |
| cfgErr | output | 1 | Captured configuration contains an illegal code |

## Verification
A cycle can end on the same edge because `readyIn` rises and because the wait counter reaches the limit. The bench provokes this by setting the ready delay d equal to the limit, for example d = 3 with code 3'b110. It judges the result by the stall count, which must still be exactly three with a single `cycDone`. The mandatory mode wait and the zero-limit exit also meet on one edge, in mode 2'b00 with limit 0. There the bench expects exactly one stall clock followed directly by `cycDone`.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int LIM_CODE_W = 3;
  localparam int MODE_W     = 2;
  localparam int WID_W      = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAND = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } bwcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } ctrlStrb_t;
endpackage

// File: rtl/bwc_datapath.sv
module bwc_datapath
  import bwc_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LIM_CODE_W-1:0] cfgLimit,
  input  logic [MODE_W-1:0]     cfgMode,
  input  logic [WID_W-1:0]      cfgWidth,
  input  logic                  widthPin,
  input  ctrlStrb_t             strb,
  output logic                  loaded,
  output logic                  limZero,
  output logic                  lastWait,
  output logic                  mandWait,
  output logic                  busIs16,
  output logic                  cfgErr
);
  localparam int CMP_W = CNT_W + 1;

  logic [LIM_CODE_W-1:0] latLim;
  logic [MODE_W-1:0]     latMode;
  logic [WID_W-1:0]      latWid;
  logic [CNT_W-1:0]      waitCnt;
  logic [CMP_W-1:0]      limVal;
  logic                  limInf;
  logic                  limIllegal;
  logic                  widIllegal;
  logic                  errInt;

  // capture configuration once, on the first clock after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loaded  <= 1'b0;
      latLim  <= '0;
      latMode <= '0;
      latWid  <= '0;
    end else if (!loaded) begin
      loaded  <= 1'b1;
      latLim  <= cfgLimit;
      latMode <= cfgMode;
      latWid  <= cfgWidth;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strb.clrCnt) begin
      waitCnt <= '0;
    end else if (strb.incCnt) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  always_comb begin
    limInf     = (latLim == 3'b111);
    limIllegal = !latLim[2] && (latLim[1:0] != 2'b00);
    widIllegal = (latWid == 2'b00);
    case (latLim)
      3'b100:  limVal = CMP_W'(1);
      3'b101:  limVal = CMP_W'(2);
      3'b110:  limVal = CMP_W'(3);
      default: limVal = '0;
    endcase
    errInt   = loaded && (limIllegal || widIllegal);
    limZero  = errInt || (!limInf && (limVal == '0));
    lastWait = !limInf && (({1'b0, waitCnt} + CMP_W'(1)) == limVal);
    mandWait = (latMode == 2'b00);
    cfgErr   = errInt;
    case (latWid)
      2'b01:   busIs16 = 1'b1;
      2'b11:   busIs16 = widthPin;
      default: busIs16 = 1'b0;
    endcase
  end
endmodule

// File: rtl/bwc_control.sv
module bwc_control
  import bwc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cycReq,
  input  logic      readyIn,
  input  logic      loaded,
  input  logic      limZero,
  input  logic      lastWait,
  input  logic      mandWait,
  output ctrlStrb_t strb,
  output logic      stall,
  output logic      cycDone
);
  bwcState_e curState, nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nxtState;
  end

  always_comb begin
    nxtState    = curState;
    strb.clrCnt = 1'b0;
    strb.incCnt = 1'b0;
    case (curState)
      ST_IDLE: begin
        if (cycReq && loaded) begin
          strb.clrCnt = 1'b1;
          if (mandWait)                nxtState = ST_MAND;
          else if (limZero || readyIn) nxtState = ST_DONE;
          else                         nxtState = ST_WAIT;
        end
      end
      ST_MAND: begin
        if (limZero || readyIn) nxtState = ST_DONE;
        else                    nxtState = ST_WAIT;
      end
      ST_WAIT: begin
        if (readyIn || lastWait) nxtState = ST_DONE;
        else                     strb.incCnt = 1'b1;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign stall   = (curState == ST_MAND) || (curState == ST_WAIT);
  assign cycDone = (curState == ST_DONE);
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LIM_CODE_W-1:0] cfgLimit,
  input  logic [MODE_W-1:0]     cfgMode,
  input  logic [WID_W-1:0]      cfgWidth,
  input  logic                  widthPin,
  input  logic                  cycReq,
  input  logic                  readyIn,
  output logic                  stall,
  output logic                  cycDone,
  output logic                  busIs16,
  output logic                  cfgErr
);
  ctrlStrb_t strb;
  logic      loaded, limZero, lastWait, mandWait;

  bwc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgLimit(cfgLimit), .cfgMode(cfgMode),
    .cfgWidth(cfgWidth), .widthPin(widthPin), .strb(strb),
    .loaded(loaded), .limZero(limZero), .lastWait(lastWait),
    .mandWait(mandWait), .busIs16(busIs16), .cfgErr(cfgErr)
  );

  bwc_control u_ctl (
    .clk(clk), .rstN(rstN), .cycReq(cycReq), .readyIn(readyIn),
    .loaded(loaded), .limZero(limZero), .lastWait(lastWait),
    .mandWait(mandWait), .strb(strb), .stall(stall), .cycDone(cycDone)
  );
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker (
  input logic clk,
  input logic rstN,
  input logic stall,
  input logic cycDone,
  input logic cfgErr
);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycDone |=> !cycDone);
  // R9
  done_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycDone |-> !stall);
  // R9
  stall_ends_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> cycDone);
  // R10
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycDone |=> !stall);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
endmodule

bind bus_wait_ctrl bwc_checker u_chk (
  .clk(clk), .rstN(rstN), .stall(stall), .cycDone(cycDone), .cfgErr(cfgErr)
);

// File: tb/bus_wait_ctrl_tb.sv
module bus_wait_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cfgLimit = '0;
  logic [1:0] cfgMode = 2'b11;
  logic [1:0] cfgWidth = 2'b01;
  logic       widthPin = 1'b0;
  logic       cycReq = 1'b0;
  logic       readyIn = 1'b0;
  logic       stall, cycDone, busIs16, cfgErr;

  int nRun = 0;
  int nFail = 0;
  int mandNow = 0;
  int stallCnt = 0;
  int doneSeen = 0;
  int expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  bus_wait_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cfgLimit(cfgLimit), .cfgMode(cfgMode),
    .cfgWidth(cfgWidth), .widthPin(widthPin), .cycReq(cycReq),
    .readyIn(readyIn), .stall(stall), .cycDone(cycDone),
    .busIs16(busIs16), .cfgErr(cfgErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: count stall clocks, compare on each done pulse
  always @(negedge clk) begin
    if (!rstN) begin
      stallCnt = 0;
    end else begin
      if (stall) stallCnt++;
      if (cycDone) begin
        doneSeen++;
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected done", 1, 0);
        end else begin
          int e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(stallCnt == e, t, stallCnt, e);
        end
        stallCnt = 0;
      end
    end
  end

  task automatic doReset(input logic [2:0] lim, input logic [1:0] md, input logic [1:0] wd);
    rstN = 1'b0;
    cycReq = 1'b0;
    readyIn = 1'b0;
    cfgLimit = lim;
    cfgMode = md;
    cfgWidth = wd;
    repeat (2) @(negedge clk);
    check(!stall && !cycDone, "R1 reset outputs", {stall, cycDone}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    mandNow = (md == 2'b00) ? 1 : 0;
  endtask

  // expected stall clocks from the requirements; lim = -1 means no limit
  function automatic int expWaits(input int lim, input bit err, input int d);
    int r;
    if (err || lim == 0) r = 0;
    else if (lim < 0) r = d;
    else r = (d < lim) ? d : lim;
    return mandNow + r;
  endfunction

  task automatic runCyc(input int d, input int exp, input int reqHold, input string tag);
    bit done = 0;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    for (int t = 0; t < 400 && !done; t++) begin
      cycReq = (t < reqHold);
      readyIn = (t >= mandNow + d);
      @(posedge clk);
      @(negedge clk);
      if (cycDone) done = 1;
    end
    if (!done) check(1'b0, {tag, " no done"}, 0, 1);
    cycReq = 1'b0;
    readyIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R2 each finite limit, ready never high
    doReset(3'b000, 2'b11, 2'b01);
    check(cfgErr == 1'b0, "R6 legal cfg no err", cfgErr, 0);
    runCyc(99, expWaits(0, 0, 99), 1, "R2 limit0");
    doReset(3'b100, 2'b11, 2'b01);
    runCyc(99, expWaits(1, 0, 99), 1, "R2 limit1");
    doReset(3'b101, 2'b11, 2'b01);
    runCyc(99, expWaits(2, 0, 99), 1, "R2 limit2");
    doReset(3'b110, 2'b11, 2'b01);
    runCyc(99, expWaits(3, 0, 99), 1, "R2 limit3");
    // R3 ready earlier / simultaneous with limit
    runCyc(0, expWaits(3, 0, 0), 1, "R3 d0");
    runCyc(1, expWaits(3, 0, 1), 1, "R3 d1");
    runCyc(3, expWaits(3, 0, 3), 1, "R3 d equals limit");
    // R1 configuration change after load ignored
    cfgLimit = 3'b000;
    cfgWidth = 2'b10;
    @(negedge clk);
    check(busIs16 == 1'b1, "R1 width unchanged", busIs16, 1);
    runCyc(99, expWaits(3, 0, 99), 1, "R1 limit unchanged");
    // R10 request held through wait states
    doneSeen = 0;
    runCyc(99, expWaits(3, 0, 99), 4, "R10 held request");
    repeat (8) @(negedge clk);
    check(doneSeen == 1, "R10 single cycle", doneSeen, 1);
    // R4 infinite
    doReset(3'b111, 2'b11, 2'b01);
    runCyc(20, expWaits(-1, 0, 20), 1, "R4 infinite d20");
    runCyc(0, expWaits(-1, 0, 0), 1, "R4 infinite d0");
    // R5 zero limit ignores ready in both directions
    doReset(3'b000, 2'b01, 2'b01);
    runCyc(50, expWaits(0, 0, 50), 1, "R5 ready ignored");
    // R6 illegal limit codes
    for (int c = 1; c < 4; c++) begin
      doReset(3'(c), 2'b11, 2'b01);
      check(cfgErr == 1'b1, "R6 illegal code err", cfgErr, 1);
      runCyc(5, expWaits(0, 1, 5), 1, "R6 illegal acts zero");
    end
    // R7 modes
    doReset(3'b000, 2'b00, 2'b01);
    runCyc(50, expWaits(0, 0, 50), 1, "R7 mode00 limit0");
    doReset(3'b101, 2'b00, 2'b01);
    runCyc(99, expWaits(2, 0, 99), 1, "R7 mode00 limit2");
    runCyc(0, expWaits(2, 0, 0), 1, "R7 mode00 ready early");
    doReset(3'b101, 2'b01, 2'b01);
    runCyc(99, expWaits(2, 0, 99), 1, "R7 mode01");
    doReset(3'b101, 2'b10, 2'b01);
    runCyc(99, expWaits(2, 0, 99), 1, "R7 mode10");
    // R8 width decode
    doReset(3'b100, 2'b11, 2'b10);
    check(busIs16 == 1'b0 && !cfgErr, "R8 width 8", busIs16, 0);
    doReset(3'b100, 2'b11, 2'b11);
    widthPin = 1'b1;
    @(negedge clk);
    check(busIs16 == 1'b1, "R8 pin high", busIs16, 1);
    widthPin = 1'b0;
    @(negedge clk);
    check(busIs16 == 1'b0, "R8 pin low", busIs16, 0);
    doReset(3'b100, 2'b11, 2'b00);
    check(cfgErr == 1'b1 && busIs16 == 1'b0, "R8 width illegal", {cfgErr, busIs16}, 2);
    runCyc(9, expWaits(0, 1, 9), 1, "R8 illegal width acts zero");
    // R9 done pulse after last wait, already judged by monitor counts
    check(expQ.size() == 0, "R9 all done pulses seen", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule